// File: doc/BRIEF.md
# PCI DMA Window Address Translator

This block maps inbound PCI DMA bus addresses onto system memory addresses. Four programmable windows decide the mapping. Each window holds a base, a size mask and a translated base. A window works either as a direct linear map or as a scatter-gather map that fetches one page-table entry from memory.

Apart from the windows, the block has two fixed decodes for dual-address-cycle (above 4 GB) traffic. One is a large identity region. The other is a scatter-gather path through the last window. A control register can also carve a legacy hole out of the low megabyte.

A request carries one 64-bit bus address. If no page-table entry is needed, the result comes back on the next cycle. For a scatter-gather hit, the block issues exactly one 64-bit read on a memory read port with a valid/ready handshake, then waits for the data beat. The response gives the final system address, the offset mask that applies to it, and a hit flag; a clear hit flag means a fault. Only one request is in flight at a time.

Top module: `dma_win_xlate`

## Requirements
- R1: After reset all registers read zero, except the last window's base, which reads 0x2. `busy`, `rsp_valid` and `mem_rd_valid` are low.
- R2: Register index map: window i base at i, mask at 4+i, translated base at 8+i, control at 12. Write masks:
  - bases 0..2 keep 0xFFF00003;
  - base 3 keeps 0x80FFF00001 and always reads bit 1 set;
  - masks keep 0xFFF00000;
  - translated bases keep 0x7FFFFFC00;
  - control keeps bits 6 and 5.
  
  Other indices read zero and ignore writes.
- R3: Window enable and hit test:
  - Base bit 0 enables a window.
  - An address hits when (addr AND NOT (mask OR 0xFFFFF)) equals (base AND 0xFFF00000).
  - A disabled window never hits.
- R4: A direct window (base bit 1 clear) returns offset mask E = mask OR 0xFFFFF and address (tbase AND NOT E) OR (addr AND E).
- R5: A scatter-gather window (base bit 1 set) reads the entry at (tbase AND NOT (mask >> 10)) OR ((addr AND (mask OR 0xFE000)) >> 10).
  - The block issues exactly one read.
  - The read's valid and address are held stable until ready.
- R6: Entry handling:
  - An entry with bit 0 set yields address ((entry AND 0x3FFFFE) << 12) OR (addr AND 0x1FFF), with offset mask 0x1FFF.
  - An entry with bit 0 clear is a fault.
- R7: With control bit 5 set, an address in 0x80000..0xFFFFF faults.
- R8: Window priority for addresses at or below 0xFFFFFFFF:
  - The lowest-numbered hitting window wins among windows 0, 1 and 2.
  - Window 3 takes part only when its base bit 39 (dual-address-cycle enable) is clear.
- R9: With control bit 6 set, an address in [2^40, 2^41) hits with offset mask 0x7FFFFFFFF and address (addr AND 0x7FFFFFFFF).
- R10: An address in 0x80000000000..0xFFFFFFFFFFF, with base 3 bits 0 and 39 both set, reads the entry at (tbase3 AND 0x7FFC00000) OR ((addr AND 0xFFFFE000) >> 10).
- R11: Response timing and contents:
  - A request that needs no entry is answered on the cycle after acceptance.
  - `busy` is high and `req_ready` low from acceptance of a scatter-gather request until its response.
  - A fault returns zero address and zero mask.
  - A hit's address agrees with the bus address on every mask bit.
- R12: An address that matches no window or fixed decode faults.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| csr_we | input | 1 | Register write strobe |
| csr_idx | input | 4 | Register index for write and read |
| csr_wdata | input | 64 | Register write data |
| csr_rdata | output | 64 | Read data for `csr_idx` (combinational) |
| req_valid | input | 1 | Translation request valid |
| req_ready | output | 1 | Block can accept a request |
| req_addr | input | 64 | PCI bus address to translate |
| busy | output | 1 | A page-table fetch is in progress |
| mem_rd_valid | output | 1 | Page-table read request valid |
| mem_rd_ready | input | 1 | Memory accepts the read |
| mem_rd_addr | output | 64 | Page-table entry address |
| mem_rd_data_valid | input | 1 | Read data beat valid |
| mem_rd_data | input | 64 | Page-table entry |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_hit | output | 1 | 1 = translated, 0 = fault |
| rsp_addr | output | 64 | Translated system address |
| rsp_ofs | output | 64 | Offset mask of the mapping |

## Verification
The assertions check on every cycle:
- that the page-table read holds its address while stalled and issues only once;
- that fault responses carry zeros and hit responses preserve the offset bits;
- that an entry with bit 0 clear turns into a fault;
- that the hole and the identity region answer on the next cycle.

Only the bench scenarios can show:
- the window arithmetic itself, for direct and page-table results;
- the window priority and the window 3 exclusion once bit 39 is set;
- the register write masks.

The bench shows these by comparing every response against a model held in the bench, with its own shadow copy of the registers.

// File: rtl/dwx_pkg.sv
package dwx_pkg;
  localparam int XW = 64;

  localparam logic [XW-1:0] SPAN_MIN       = 64'h0000_0000_000F_FFFF;
  localparam logic [XW-1:0] BASE_ADDR_BITS = 64'h0000_0000_FFF0_0000;
  localparam logic [XW-1:0] BASE_KEEP      = 64'h0000_0000_FFF0_0003;
  localparam logic [XW-1:0] BASE_LAST_KEEP = 64'h0000_0080_FFF0_0001;
  localparam logic [XW-1:0] MASK_KEEP      = 64'h0000_0000_FFF0_0000;
  localparam logic [XW-1:0] TBA_KEEP       = 64'h0000_0007_FFFF_FC00;
  localparam logic [XW-1:0] CTRL_KEEP      = 64'h0000_0000_0000_0060;
  localparam logic [XW-1:0] SG_FORCE       = 64'h0000_0000_0000_0002;
  localparam logic [XW-1:0] SG_IDX_BITS    = 64'h0000_0000_000F_E000;
  localparam logic [XW-1:0] PTE_PAGE_BITS  = 64'h0000_0000_003F_FFFE;
  localparam logic [XW-1:0] PAGE_OFS       = 64'h0000_0000_0000_1FFF;
  localparam logic [XW-1:0] IDMAP_OFS      = 64'h0000_0007_FFFF_FFFF;
  localparam logic [XW-1:0] DAC_TBA_KEEP   = 64'h0000_0007_FFC0_0000;
  localparam logic [XW-1:0] DAC_IDX_BITS   = 64'h0000_0000_FFFF_E000;
  localparam logic [XW-1:0] HOLE_LO        = 64'h0000_0000_0008_0000;
  localparam logic [XW-1:0] HOLE_HI        = 64'h0000_0000_000F_FFFF;

  localparam int BIT_EN    = 0;
  localparam int BIT_SG    = 1;
  localparam int BIT_DAC   = 39;
  localparam int BIT_HOLE  = 5;
  localparam int BIT_IDMAP = 6;

  typedef enum logic [1:0] {XK_FAULT = 2'd0, XK_DIRECT = 2'd1, XK_SG = 2'd2} xkind_e;

  typedef struct packed {
    xkind_e          kind;
    logic [XW-1:0]   base;
    logic [XW-1:0]   ofs;
    logic [XW-1:0]   pte_addr;
  } xdec_t;

  function automatic logic [XW-1:0] span_mask(input logic [XW-1:0] m);
    return m | SPAN_MIN;
  endfunction

  function automatic logic win_match(input logic [XW-1:0] base,
                                     input logic [XW-1:0] m,
                                     input logic [XW-1:0] a);
    return (a & ~span_mask(m)) == (base & BASE_ADDR_BITS);
  endfunction

  function automatic logic [XW-1:0] sg_pte_addr(input logic [XW-1:0] tba,
                                                input logic [XW-1:0] m,
                                                input logic [XW-1:0] a);
    return (tba & ~(m >> 10)) | ((a & (m | SG_IDX_BITS)) >> 10);
  endfunction

  function automatic logic [XW-1:0] dac_pte_addr(input logic [XW-1:0] tba,
                                                 input logic [XW-1:0] a);
    return (tba & DAC_TBA_KEEP) | ((a & DAC_IDX_BITS) >> 10);
  endfunction

  function automatic logic [XW-1:0] pte_page(input logic [XW-1:0] pte);
    return (pte & PTE_PAGE_BITS) << 12;
  endfunction

  function automatic logic [XW-1:0] merge(input logic [XW-1:0] base,
                                          input logic [XW-1:0] ofs,
                                          input logic [XW-1:0] a);
    return base | (a & ofs);
  endfunction
endpackage

// File: rtl/dwx_csr.sv
module dwx_csr import dwx_pkg::*; #(
  parameter int NUM_WIN = 4,
  parameter int IDX_W   = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we_i,
  input  logic [IDX_W-1:0]  idx_i,
  input  logic [XW-1:0]     wdata_i,
  output logic [XW-1:0]     rdata_o,
  output logic [XW-1:0]     base_o [NUM_WIN],
  output logic [XW-1:0]     mask_o [NUM_WIN],
  output logic [XW-1:0]     tba_o  [NUM_WIN],
  output logic [XW-1:0]     ctrl_o
);
  localparam int LAST = NUM_WIN - 1;

  logic [XW-1:0] base_q [NUM_WIN];
  logic [XW-1:0] mask_q [NUM_WIN];
  logic [XW-1:0] tba_q  [NUM_WIN];
  logic [XW-1:0] ctrl_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_WIN; i++) begin
        base_q[i] <= (i == LAST) ? SG_FORCE : '0;
        mask_q[i] <= '0;
        tba_q[i]  <= '0;
      end
      ctrl_q <= '0;
    end else if (we_i) begin
      for (int i = 0; i < NUM_WIN; i++) begin
        if (idx_i == IDX_W'(i))
          base_q[i] <= (i == LAST) ? ((wdata_i & BASE_LAST_KEEP) | SG_FORCE)
                                   : (wdata_i & BASE_KEEP);
        if (idx_i == IDX_W'(NUM_WIN + i))
          mask_q[i] <= wdata_i & MASK_KEEP;
        if (idx_i == IDX_W'(2 * NUM_WIN + i))
          tba_q[i] <= wdata_i & TBA_KEEP;
      end
      if (idx_i == IDX_W'(3 * NUM_WIN))
        ctrl_q <= wdata_i & CTRL_KEEP;
    end
  end

  always_comb begin
    rdata_o = '0;
    for (int i = 0; i < NUM_WIN; i++) begin
      if (idx_i == IDX_W'(i))               rdata_o = base_q[i];
      if (idx_i == IDX_W'(NUM_WIN + i))     rdata_o = mask_q[i];
      if (idx_i == IDX_W'(2 * NUM_WIN + i)) rdata_o = tba_q[i];
    end
    if (idx_i == IDX_W'(3 * NUM_WIN)) rdata_o = ctrl_q;
  end

  assign base_o = base_q;
  assign mask_o = mask_q;
  assign tba_o  = tba_q;
  assign ctrl_o = ctrl_q;

  // R2: the last window never loses its scatter-gather selection
  p_last_sg_r2: assert property (@(posedge clk) disable iff (!rst_n)
    we_i && idx_i == IDX_W'(LAST) |=> base_q[LAST][BIT_SG]);
endmodule

// File: rtl/dwx_win_match.sv
module dwx_win_match import dwx_pkg::*; (
  input  logic [XW-1:0] base_i,
  input  logic [XW-1:0] mask_i,
  input  logic [XW-1:0] tba_i,
  input  logic [XW-1:0] addr_i,
  output logic          hit_o,
  output logic          sg_o,
  output logic [XW-1:0] dir_base_o,
  output logic [XW-1:0] dir_ofs_o,
  output logic [XW-1:0] pte_addr_o
);
  assign hit_o      = base_i[BIT_EN] && win_match(base_i, mask_i, addr_i);
  assign sg_o       = base_i[BIT_SG];
  assign dir_ofs_o  = span_mask(mask_i);
  assign dir_base_o = tba_i & ~span_mask(mask_i);
  assign pte_addr_o = sg_pte_addr(tba_i, mask_i, addr_i);
endmodule

// File: rtl/dwx_seq.sv
module dwx_seq import dwx_pkg::*; (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid_i,
  input  logic [XW-1:0] req_addr_i,
  input  xdec_t         dec_i,
  output logic          req_ready_o,
  output logic          busy_o,
  output logic          mem_rd_valid_o,
  input  logic          mem_rd_ready_i,
  output logic [XW-1:0] mem_rd_addr_o,
  input  logic          mem_rd_data_valid_i,
  input  logic [XW-1:0] mem_rd_data_i,
  output logic          rsp_valid_o,
  output logic          rsp_hit_o,
  output logic [XW-1:0] rsp_addr_o,
  output logic [XW-1:0] rsp_ofs_o
);
  typedef enum logic [1:0] {ST_IDLE = 2'd0, ST_FETCH = 2'd1, ST_WAIT = 2'd2} st_e;

  st_e           st_q;
  logic [XW-1:0] req_q;
  logic [XW-1:0] pte_addr_q;
  logic          from_pte_q;
  logic          pte_ok;
  logic          pte_done;
  logic          is_direct;

  assign pte_ok    = mem_rd_data_i[BIT_EN];
  assign pte_done  = (st_q == ST_WAIT) && mem_rd_data_valid_i;
  assign is_direct = (dec_i.kind == XK_DIRECT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q        <= ST_IDLE;
      req_q       <= '0;
      pte_addr_q  <= '0;
      from_pte_q  <= 1'b0;
      rsp_valid_o <= 1'b0;
      rsp_hit_o   <= 1'b0;
      rsp_addr_o  <= '0;
      rsp_ofs_o   <= '0;
    end else begin
      rsp_valid_o <= 1'b0;
      case (st_q)
        ST_IDLE: if (req_valid_i) begin
          req_q <= req_addr_i;
          if (dec_i.kind == XK_SG) begin
            pte_addr_q <= dec_i.pte_addr;
            st_q       <= ST_FETCH;
          end else begin
            rsp_valid_o <= 1'b1;
            from_pte_q  <= 1'b0;
            rsp_hit_o   <= is_direct;
            rsp_addr_o  <= is_direct ? merge(dec_i.base, dec_i.ofs, req_addr_i) : '0;
            rsp_ofs_o   <= is_direct ? dec_i.ofs : '0;
          end
        end
        ST_FETCH: if (mem_rd_ready_i) st_q <= ST_WAIT;
        ST_WAIT: if (mem_rd_data_valid_i) begin
          st_q        <= ST_IDLE;
          rsp_valid_o <= 1'b1;
          from_pte_q  <= 1'b1;
          rsp_hit_o   <= pte_ok;
          rsp_addr_o  <= pte_ok ? merge(pte_page(mem_rd_data_i), PAGE_OFS, req_q) : '0;
          rsp_ofs_o   <= pte_ok ? PAGE_OFS : '0;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign req_ready_o    = (st_q == ST_IDLE);
  assign busy_o         = (st_q != ST_IDLE);
  assign mem_rd_valid_o = (st_q == ST_FETCH);
  assign mem_rd_addr_o  = pte_addr_q;

  // R5: a stalled read keeps its request and address
  p_fetch_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_valid_o && !mem_rd_ready_i |=> mem_rd_valid_o && $stable(mem_rd_addr_o));
  // R5: exactly one read per fetch
  p_single_read_r5: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_valid_o && mem_rd_ready_i |=> !mem_rd_valid_o);
  // R6: an entry without its valid bit becomes a fault
  p_bad_pte_r6: assert property (@(posedge clk) disable iff (!rst_n)
    pte_done && !pte_ok |=> rsp_valid_o && !rsp_hit_o);
  // R6: an entry hit always carries the page offset mask
  p_pte_ofs_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid_o && rsp_hit_o && from_pte_q |-> rsp_ofs_o == PAGE_OFS);
  // R11: a fault carries no address
  p_fault_zero_r11: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid_o && !rsp_hit_o |-> rsp_addr_o == '0 && rsp_ofs_o == '0);
  // R11: a hit keeps the bus offset bits
  p_ofs_keep_r11: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid_o && rsp_hit_o |-> ((rsp_addr_o ^ req_q) & rsp_ofs_o) == '0);
  // R11: the block is free again when it responds
  p_free_on_rsp_r11: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid_o |-> !busy_o);
endmodule

// File: rtl/dma_win_xlate.sv
module dma_win_xlate import dwx_pkg::*; #(
  parameter  int NUM_WIN = 4,
  localparam int IDX_W   = $clog2(3 * NUM_WIN + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              csr_we,
  input  logic [IDX_W-1:0]  csr_idx,
  input  logic [63:0]       csr_wdata,
  output logic [63:0]       csr_rdata,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [63:0]       req_addr,
  output logic              busy,
  output logic              mem_rd_valid,
  input  logic              mem_rd_ready,
  output logic [63:0]       mem_rd_addr,
  input  logic              mem_rd_data_valid,
  input  logic [63:0]       mem_rd_data,
  output logic              rsp_valid,
  output logic              rsp_hit,
  output logic [63:0]       rsp_addr,
  output logic [63:0]       rsp_ofs
);
  localparam int LAST = NUM_WIN - 1;

  logic [XW-1:0] base_r [NUM_WIN];
  logic [XW-1:0] mask_r [NUM_WIN];
  logic [XW-1:0] tba_r  [NUM_WIN];
  logic [XW-1:0] ctrl_r;

  logic [NUM_WIN-1:0] w_hit;
  logic [NUM_WIN-1:0] w_sg;
  logic [XW-1:0]      w_base [NUM_WIN];
  logic [XW-1:0]      w_ofs  [NUM_WIN];
  logic [XW-1:0]      w_pte  [NUM_WIN];

  logic  is_sac, in_hole, idmap_rng, dac_rng, dac_en, accept;
  xdec_t dec;
  logic  unused_ctrl;

  dwx_csr #(.NUM_WIN(NUM_WIN), .IDX_W(IDX_W)) u_csr (
    .clk(clk), .rst_n(rst_n), .we_i(csr_we), .idx_i(csr_idx), .wdata_i(csr_wdata),
    .rdata_o(csr_rdata), .base_o(base_r), .mask_o(mask_r), .tba_o(tba_r), .ctrl_o(ctrl_r)
  );

  for (genvar gw = 0; gw < NUM_WIN; gw++) begin : g_win
    dwx_win_match u_match (
      .base_i(base_r[gw]), .mask_i(mask_r[gw]), .tba_i(tba_r[gw]), .addr_i(req_addr),
      .hit_o(w_hit[gw]), .sg_o(w_sg[gw]), .dir_base_o(w_base[gw]),
      .dir_ofs_o(w_ofs[gw]), .pte_addr_o(w_pte[gw])
    );
  end

  assign unused_ctrl = ^{ctrl_r[XW-1:BIT_IDMAP+1], ctrl_r[BIT_HOLE-1:0]};

  assign is_sac    = (req_addr[XW-1:32] == '0);
  assign in_hole   = is_sac && ctrl_r[BIT_HOLE] && req_addr >= HOLE_LO && req_addr <= HOLE_HI;
  assign idmap_rng = (req_addr[XW-1:41] == '0) && req_addr[40];
  assign dac_rng   = (req_addr[XW-1:44] == '0) && req_addr[43];
  assign dac_en    = base_r[LAST][BIT_DAC];
  assign accept    = req_valid && req_ready;

  always_comb begin
    dec = '0;
    if (is_sac) begin
      if (!in_hole) begin
        for (int i = LAST; i >= 0; i--) begin
          if (w_hit[i] && (i != LAST || !dac_en)) begin
            dec.kind     = w_sg[i] ? XK_SG : XK_DIRECT;
            dec.base     = w_base[i];
            dec.ofs      = w_ofs[i];
            dec.pte_addr = w_pte[i];
          end
        end
      end
    end else if (ctrl_r[BIT_IDMAP] && idmap_rng) begin
      dec.kind = XK_DIRECT;
      dec.ofs  = IDMAP_OFS;
    end else if (dac_rng && base_r[LAST][BIT_EN] && dac_en) begin
      dec.kind     = XK_SG;
      dec.pte_addr = dac_pte_addr(tba_r[LAST], req_addr);
    end
  end

  dwx_seq u_seq (
    .clk(clk), .rst_n(rst_n), .req_valid_i(req_valid), .req_addr_i(req_addr), .dec_i(dec),
    .req_ready_o(req_ready), .busy_o(busy), .mem_rd_valid_o(mem_rd_valid),
    .mem_rd_ready_i(mem_rd_ready), .mem_rd_addr_o(mem_rd_addr),
    .mem_rd_data_valid_i(mem_rd_data_valid), .mem_rd_data_i(mem_rd_data),
    .rsp_valid_o(rsp_valid), .rsp_hit_o(rsp_hit), .rsp_addr_o(rsp_addr), .rsp_ofs_o(rsp_ofs)
  );

  // R7: hole addresses fault on the next cycle
  p_hole_fault_r7: assert property (@(posedge clk) disable iff (!rst_n)
    accept && in_hole |=> rsp_valid && !rsp_hit);
  // R9: identity region answers next cycle with the masked bus address
  p_idmap_r9: assert property (@(posedge clk) disable iff (!rst_n)
    accept && !is_sac && ctrl_r[BIT_IDMAP] && idmap_rng |=>
      rsp_valid && rsp_hit && rsp_ofs == IDMAP_OFS &&
      rsp_addr == ($past(req_addr) & IDMAP_OFS));
  // R11: no request is taken while a fetch is pending
  p_no_accept_busy_r11: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_valid |-> !req_ready);
endmodule

// File: tb/tb_dma_win_xlate.sv
`timescale 1ns/1ps
module tb_dma_win_xlate;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        csr_we = 1'b0;
  logic [3:0]  csr_idx = '0;
  logic [63:0] csr_wdata = '0;
  logic [63:0] csr_rdata;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [63:0] req_addr = '0;
  logic        busy;
  logic        mem_rd_valid;
  logic        mem_rd_ready;
  logic [63:0] mem_rd_addr;
  logic        mem_rd_data_valid;
  logic [63:0] mem_rd_data;
  logic        rsp_valid, rsp_hit;
  logic [63:0] rsp_addr, rsp_ofs;

  always #2 clk = ~clk;

  dma_win_xlate dut (
    .clk(clk), .rst_n(rst_n), .csr_we(csr_we), .csr_idx(csr_idx), .csr_wdata(csr_wdata),
    .csr_rdata(csr_rdata), .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
    .busy(busy), .mem_rd_valid(mem_rd_valid), .mem_rd_ready(mem_rd_ready),
    .mem_rd_addr(mem_rd_addr), .mem_rd_data_valid(mem_rd_data_valid), .mem_rd_data(mem_rd_data),
    .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_addr(rsp_addr), .rsp_ofs(rsp_ofs)
  );

  int total = 0;
  int bad = 0;
  bit done = 0;

  logic [63:0] sb [4];
  logic [63:0] sm [4];
  logic [63:0] st [4];
  logic [63:0] sc;

  logic [128:0] exp_q [$];
  string        tag_q [$];
  logic [63:0]  exp_pa;

  task automatic chk(input bit ok, input string tag, input logic [128:0] act, input logic [128:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [63:0] mem_word(input logic [63:0] a);
    return ((a * 64'h9E37) & 64'h3F_FFFE) | {63'b0, ~a[3]};
  endfunction

  // bench model of the translation, built from the requirement text
  function automatic void model(input logic [63:0] a, output bit sg, output logic [63:0] pa,
                                output bit hit, output logic [63:0] res, output logic [63:0] msk);
    logic [63:0] e;
    logic [63:0] pte;
    sg = 0; pa = '0; hit = 0; res = '0; msk = '0;
    if (a <= 64'hFFFF_FFFF) begin
      if (!(sc[5] && a >= 64'h8_0000 && a <= 64'hF_FFFF)) begin
        for (int w = 0; w < 4; w++) begin
          e = sm[w] | 64'hF_FFFF;
          if (!(w == 3 && sb[3][39]) && sb[w][0] && ((a & ~e) == (sb[w] & 64'hFFF0_0000))) begin
            if (sb[w][1]) begin
              sg = 1;
              pa = (st[w] & ~(sm[w] >> 10)) | ((a & (sm[w] | 64'hF_E000)) >> 10);
            end else begin
              hit = 1; msk = e; res = (st[w] & ~e) | (a & e);
            end
            break;
          end
        end
      end
    end else if (sc[6] && a >= (64'd1 << 40) && a < (64'd1 << 41)) begin
      hit = 1; msk = 64'h7_FFFF_FFFF; res = a & msk;
    end else if (a >= 64'h800_0000_0000 && a <= 64'hFFF_FFFF_FFFF && sb[3][0] && sb[3][39]) begin
      sg = 1;
      pa = (st[3] & 64'h7_FFC0_0000) | ((a & 64'hFFFF_E000) >> 10);
    end
    if (sg) begin
      pte = mem_word(pa);
      if (pte[0]) begin
        hit = 1; msk = 64'h1FFF; res = ((pte & 64'h3F_FFFE) << 12) | (a & 64'h1FFF);
      end
    end
  endfunction

  task automatic csr_wr(input int idx, input logic [63:0] v);
    @(negedge clk);
    csr_we = 1'b1; csr_idx = 4'(idx); csr_wdata = v;
    @(negedge clk);
    csr_we = 1'b0;
    if (idx < 4) sb[idx] = (idx == 3) ? ((v & 64'h80_FFF0_0001) | 64'h2) : (v & 64'hFFF0_0003);
    else if (idx < 8) sm[idx-4] = v & 64'hFFF0_0000;
    else if (idx < 12) st[idx-8] = v & 64'h7_FFFF_FC00;
    else if (idx == 12) sc = v & 64'h60;
  endtask

  task automatic csr_chk(input int idx, input logic [63:0] exp, input string tag);
    @(negedge clk);
    csr_idx = 4'(idx);
    #1;
    chk(csr_rdata == exp, tag, {65'b0, csr_rdata}, {65'b0, exp});
  endtask

  // driver: pushes the expected response, then issues the request
  task automatic xreq(input logic [63:0] a, input string tag);
    bit sg, hit;
    logic [63:0] pa, res, msk;
    model(a, sg, pa, hit, res, msk);
    exp_q.push_back({hit, res, msk});
    tag_q.push_back(tag);
    exp_pa = pa;
    @(negedge clk);
    req_valid = 1'b1; req_addr = a;
    @(negedge clk);
    req_valid = 1'b0;
    if (!sg) chk(rsp_valid == 1'b1, "R11 next-cycle response", {128'b0, rsp_valid}, 129'd1);
    else chk(busy && !req_ready, "R11 busy during fetch", {127'b0, busy, req_ready}, 129'd2);
    while (exp_q.size() != 0) @(negedge clk);
    @(negedge clk);
  endtask

  // monitor: compares each response with the queue head
  always @(negedge clk) begin
    if (rst_n && rsp_valid) begin
      if (exp_q.size() == 0) begin
        chk(1'b0, "R11 unexpected response", {rsp_hit, rsp_addr, rsp_ofs}, 129'd0);
      end else begin
        logic [128:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        chk({rsp_hit, rsp_addr, rsp_ofs} == e, t, {rsp_hit, rsp_addr, rsp_ofs}, e);
      end
    end
  end

  // memory model: one stall cycle, then a data beat two cycles after the handshake
  initial begin
    mem_rd_ready = 1'b0; mem_rd_data_valid = 1'b0; mem_rd_data = '0;
    forever begin
      @(negedge clk);
      if (rst_n && mem_rd_valid) begin
        logic [63:0] la;
        la = mem_rd_addr;
        chk(la == exp_pa, "R5 entry address (R10 for high range)", {65'b0, la}, {65'b0, exp_pa});
        @(negedge clk);
        chk(mem_rd_valid && mem_rd_addr == la, "R5 read held while stalled",
            {64'b0, mem_rd_valid, mem_rd_addr}, {64'b1, la});
        mem_rd_ready = 1'b1;
        @(negedge clk);
        mem_rd_ready = 1'b0;
        chk(!mem_rd_valid, "R5 single read", {128'b0, mem_rd_valid}, 129'd0);
        @(negedge clk);
        mem_rd_data_valid = 1'b1; mem_rd_data = mem_word(la);
        @(negedge clk);
        mem_rd_data_valid = 1'b0;
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 4; i++) begin sb[i] = '0; sm[i] = '0; st[i] = '0; end
    sb[3] = 64'h2; sc = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(!busy && !rsp_valid && !mem_rd_valid && req_ready, "R1 idle after reset",
        {125'b0, busy, rsp_valid, mem_rd_valid, req_ready}, 129'd1);
    csr_chk(3, 64'h2, "R1 last base reset");
    csr_chk(0, 64'h0, "R1 base0 reset");
    csr_chk(9, 64'h0, "R1 tbase1 reset");
    csr_chk(12, 64'h0, "R1 control reset");

    // R2 write masks
    csr_wr(0, '1);  csr_chk(0, 64'hFFF0_0003, "R2 base0 mask");
    csr_wr(3, '1);  csr_chk(3, 64'h80_FFF0_0003, "R2 base3 mask");
    csr_wr(3, '0);  csr_chk(3, 64'h2, "R2 base3 keeps sg");
    csr_wr(5, '1);  csr_chk(5, 64'hFFF0_0000, "R2 mask1 mask");
    csr_wr(10, '1); csr_chk(10, 64'h7_FFFF_FC00, "R2 tbase2 mask");
    csr_wr(12, '1); csr_chk(12, 64'h60, "R2 control mask");
    csr_wr(13, '1); csr_chk(13, 64'h0, "R2 unmapped index");
    csr_chk(12, 64'h60, "R2 unmapped write ignored");

    // window setup
    csr_wr(12, 64'h0);
    csr_wr(0, 64'h0010_0001); csr_wr(4, 64'h0);         csr_wr(8, 64'h4000_0000);
    csr_wr(1, 64'h0020_0003); csr_wr(5, 64'h0010_0000); csr_wr(9, 64'h1234_0000);
    csr_wr(2, 64'h0010_0001); csr_wr(6, 64'h0);         csr_wr(10, 64'h5000_0000);
    csr_wr(3, 64'h0040_0001); csr_wr(7, 64'h0);         csr_wr(11, 64'h0200_0000);

    xreq(64'h0012_3456, "R4 direct hit, R8 window0 over window2");
    xreq(64'h001F_FFFF, "R4 direct top of window");
    xreq(64'h0023_5678, "R5 R6 sg window1");
    xreq(64'h0023_7000, "R6 sg window1 entry");
    xreq(64'h003F_E123, "R6 sg window1 upper");
    xreq(64'h0040_0008, "R8 window3 sac sg");
    xreq(64'h0041_2340, "R6 window3 sac entry");
    xreq(64'h0090_0000, "R12 no window");
    xreq(64'h1_0000_0000, "R12 high unmatched");

    csr_wr(0, 64'h0010_0000);
    xreq(64'h0012_3456, "R3 disabled window0, R8 falls to window2");

    csr_wr(2, 64'h0000_0001);
    xreq(64'h0009_0000, "R7 hole off hits");
    csr_wr(12, 64'h20);
    xreq(64'h0009_0000, "R7 hole fault");
    xreq(64'h0007_FFFF, "R7 below hole");
    xreq(64'h0012_3456, "R3 R12 disabled window miss");

    csr_wr(12, 64'h40);
    xreq(64'h100_0000_1234, "R9 identity low");
    xreq(64'h1FF_FFFF_FFFF, "R9 identity top");
    xreq(64'h200_0000_0000, "R9 R12 above identity");
    csr_wr(12, 64'h0);
    xreq(64'h100_0000_1234, "R9 identity off faults");

    xreq(64'h800_1234_5678, "R10 dual window disabled faults");
    csr_wr(3, 64'h80_0040_0001);
    csr_wr(11, 64'h7_FFFF_FC00);
    xreq(64'h0040_0008, "R8 window3 excluded when dual set");
    xreq(64'h800_1234_5678, "R10 dual sg");
    xreq(64'h800_1234_5688, "R10 dual sg second");
    xreq(64'hFFF_FFFF_E000, "R10 dual top");
    xreq(64'h7FF_FFFF_FFFF, "R12 below dual range");

    repeat (4) @(negedge clk);
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule